// File: doc/BRIEF.md
# Dual-Clock Leaf Interrupt Collector

This block gathers 98 interrupt sources into a pending image of four 32-bit groups and reduces that image to a single summary wire for an upstream aggregator. Source index `n` occupies group `n/32`, bit `n%32`. Indices 98 to 127 of the image have no source.

Sources 0 to 30 are produced in a separate compute clock that has its own reset. Indices 0 to 5 are level flags: four floating-point status flags and two memory ECC flags, one correctable and one uncorrectable. Each of them passes through a two-flop synchroniser into the fabric clock. Indices 6 to 30 are edge events: nine notification events, then eight write-buffer drop events, then eight write-buffer full events. Each one flips a toggle flop in the compute clock. The fabric side turns every observed change back into a one-cycle pulse, so an event one compute cycle wide is never lost. Indices 31 to 97 are edge events that already live in the fabric clock and are used without any crossing logic.

Every pending bit has a mask bit and is cleared by writing a one to it. The summary is the registered OR of all pending bits that are not masked. Every source, the uncorrectable ECC flag included, only raises this one generic summary.

Top module: `irq_leaf_collector`

## Requirements
- R1: After fabric reset, every pending bit is 0, every mask bit is 1 and `irq_summary_o` is 0.
- R2: If a fabric-clock event input `fab_evt_i[k]` (source 31+k) is 1 at a `clk_fab` rising edge, pending bit 31+k is 1 after that edge.
- R3: A compute-clock event `src_evt_i[k]` (source 6+k) that is 1 for a single `clk_src` cycle sets pending bit 6+k within 5 `clk_fab` cycles, even when the `clk_src` period is shorter than the `clk_fab` period. Events on one source spaced at least 4 fabric cycles apart each arrive.
- R4: A compute-clock level `src_lvl_i[k]` (source k, k<6) sets pending bit k while it is high. The bit stays set after the level falls and is cleared only by a write. A clear issued while the level is still high leaves the bit set.
- R5: A cycle with `clr_we_i`=1 clears pending bit `clr_grp_i*32+i` for every `i` where `clr_wdata_i[i]`=1. Zero bits in the data change nothing. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: A cycle with `mask_we_i`=1 replaces the 32 mask bits of group `mask_grp_i` with `mask_wdata_i`. A set mask bit keeps its pending bit out of the summary, but the pending bit is still latched.
- R7: `irq_summary_o` is the OR over all indices of (pending AND NOT mask), taken from the image as it stood before the previous `clk_fab` rising edge. The summary therefore trails the pending image by one cycle.
- R8: Image bits 98 to 127 always read 0.
- R9: While `rst_src_n` is low, sources 0 to 30 set no pending bit. Releasing `rst_src_n` produces no spurious event.
- R10: `pend_rd_o` shows pending group `rd_grp_i` without delay: bit i of the output is image index `rd_grp_i*32+i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fab | input | 1 | Fabric clock |
| rst_fab_n | input | 1 | Fabric reset, asynchronous, active low |
| clk_src | input | 1 | Compute-domain clock |
| rst_src_n | input | 1 | Compute-domain reset, active low |
| src_lvl_i | input | 6 | Compute-domain level flags, sources 0..5 |
| src_evt_i | input | 25 | Compute-domain event pulses, sources 6..30 |
| fab_evt_i | input | 67 | Fabric-domain event pulses, sources 31..97 |
| mask_we_i | input | 1 | Mask group write strobe |
| mask_grp_i | input | 2 | Group selected for the mask write |
| mask_wdata_i | input | 32 | New mask bits for that group |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_grp_i | input | 2 | Group selected for clearing |
| clr_wdata_i | input | 32 | Ones mark the pending bits to clear |
| rd_grp_i | input | 2 | Group shown on pend_rd_o |
| pend_rd_o | output | 32 | Pending bits of the selected group |
| irq_summary_o | output | 1 | Registered OR of unmasked pending bits |

## Verification
The hardest cases sit on the compute-clock side. One is an event pulse narrower than a fabric period, which plain sampling would miss. Another is a level flag that stays high through a clear and through a compute-domain reset. The bench runs the compute clock at a 7 ns period against the 20 ns fabric clock and drives single compute-cycle pulses, so only the toggle transfer can deliver them. It also holds a level high while it pulses `rst_src_n` and issues a clear in that window. During each crossing the reference model marks the crossing bits as unsettled. Once the synchroniser latency has passed, it lands the expected bit and resumes exact comparison on every cycle.

// File: rtl/irq_leaf_pkg.sv
`timescale 1ns/1ps
package irq_leaf_pkg;
  localparam int NUM_SRC  = 98;
  localparam int GRP_W    = 32;
  localparam int NUM_GRP  = 4;
  localparam int IMG_W    = GRP_W * NUM_GRP;
  localparam int GSEL_W   = $clog2(NUM_GRP);
  localparam int XDOM_CNT = 31;
  localparam int LVL_CNT  = 6;

  // source attribute: crosses from the compute clock
  function automatic bit src_crosses(input int idx, input int xdom);
    return idx < xdom;
  endfunction

  // source attribute: level rather than edge
  function automatic bit src_is_level(input int idx, input int lvl);
    return idx < lvl;
  endfunction

  // spread one group word over the full image
  function automatic logic [IMG_W-1:0] place_grp(input logic [GSEL_W-1:0] g,
                                                 input logic [GRP_W-1:0] d);
    logic [IMG_W-1:0] r;
    r = '0;
    r[int'(g)*GRP_W +: GRP_W] = d;
    return r;
  endfunction

  // reduction feeding the summary flop
  function automatic logic any_live(input logic [IMG_W-1:0] pend,
                                    input logic [IMG_W-1:0] mask);
    return |(pend & ~mask);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/irq_lvl_sync.sv
`timescale 1ns/1ps
module irq_lvl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_evt_xfer.sv
`timescale 1ns/1ps
module irq_evt_xfer (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic evt_i,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse_o
);
  logic       tog_q;
  logic [2:0] sy_q;
  logic [2:0] arm_q;

  // source side: every event flips the toggle
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_q ^ evt_i;
  end

  // destination side: two stages plus a history flop, armed once history is valid
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      sy_q  <= 3'b000;
      arm_q <= 3'b000;
    end else begin
      sy_q  <= {sy_q[1:0], tog_q};
      arm_q <= {arm_q[1:0], 1'b1};
    end
  end

  assign pulse_o = arm_q[2] & (sy_q[1] ^ sy_q[2]);
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank
  import irq_leaf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IMG_W-1:0]  set_i,
  input  logic              mask_we_i,
  input  logic [GSEL_W-1:0] mask_grp_i,
  input  logic [GRP_W-1:0]  mask_wdata_i,
  input  logic              clr_we_i,
  input  logic [GSEL_W-1:0] clr_grp_i,
  input  logic [GRP_W-1:0]  clr_wdata_i,
  input  logic [GSEL_W-1:0] rd_grp_i,
  output logic [GRP_W-1:0]  pend_rd_o,
  output logic              summary_o
);
  localparam logic [IMG_W-1:0] USED_BITS = {{(IMG_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}};

  logic [IMG_W-1:0] pend_q, mask_q;
  logic [IMG_W-1:0] live_set, clr_vec;
  logic             summary_q;

  assign live_set = set_i & USED_BITS;
  assign clr_vec  = clr_we_i ? place_grp(clr_grp_i, clr_wdata_i) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_vec) | live_set;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mask_q[g*GRP_W +: GRP_W] <= '1;
      else if (mask_we_i && (mask_grp_i == GSEL_W'(g)))
        mask_q[g*GRP_W +: GRP_W] <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary_q <= 1'b0;
    else        summary_q <= any_live(pend_q, mask_q);
  end

  assign pend_rd_o = pend_q[int'(rd_grp_i)*GRP_W +: GRP_W];
  assign summary_o = summary_q;

  // R2 R4
  sets_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(live_set)) == $past(live_set)));

  // R5
  clear_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((pend_q & $past(clr_vec & ~live_set)) == '0));

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_q[int'($past(mask_grp_i))*GRP_W +: GRP_W] == $past(mask_wdata_i)));

  // R7
  summary_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary_o == $past(any_live(pend_q, mask_q))));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[IMG_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/irq_leaf_collector.sv
`timescale 1ns/1ps
module irq_leaf_collector
  import irq_leaf_pkg::*;
#(
  parameter int XDOM_N = XDOM_CNT,
  parameter int LVL_N  = LVL_CNT,
  localparam int SEVT_N = XDOM_N - LVL_N,
  localparam int FEVT_N = NUM_SRC - XDOM_N
) (
  input  logic              clk_fab,
  input  logic              rst_fab_n,
  input  logic              clk_src,
  input  logic              rst_src_n,
  input  logic [LVL_N-1:0]  src_lvl_i,
  input  logic [SEVT_N-1:0] src_evt_i,
  input  logic [FEVT_N-1:0] fab_evt_i,
  input  logic              mask_we_i,
  input  logic [GSEL_W-1:0] mask_grp_i,
  input  logic [GRP_W-1:0]  mask_wdata_i,
  input  logic              clr_we_i,
  input  logic [GSEL_W-1:0] clr_grp_i,
  input  logic [GRP_W-1:0]  clr_wdata_i,
  input  logic [GSEL_W-1:0] rd_grp_i,
  output logic [GRP_W-1:0]  pend_rd_o,
  output logic              irq_summary_o
);
  logic [NUM_SRC-1:0] raw_src;
  logic [IMG_W-1:0]   set_vec;
  logic               rst_xdom_n;

  assign raw_src = {fab_evt_i, src_evt_i, src_lvl_i};

  // crossing logic leaves reset only when both resets are gone, released on clk_fab
  irq_rst_sync u_xdom_rst (
    .clk     (clk_fab),
    .arst_n  (rst_src_n & rst_fab_n),
    .rst_n_o (rst_xdom_n)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (src_crosses(i, XDOM_N)) begin : g_x
      if (src_is_level(i, LVL_N)) begin : g_lvl
        irq_lvl_sync u_sync (
          .clk   (clk_fab),
          .rst_n (rst_xdom_n),
          .d_i   (raw_src[i]),
          .q_o   (set_vec[i])
        );
      end else begin : g_evt
        irq_evt_xfer u_xfer (
          .src_clk   (clk_src),
          .src_rst_n (rst_src_n),
          .evt_i     (raw_src[i]),
          .dst_clk   (clk_fab),
          .dst_rst_n (rst_xdom_n),
          .pulse_o   (set_vec[i])
        );
      end
    end else begin : g_local
      assign set_vec[i] = raw_src[i];
    end
  end

  assign set_vec[IMG_W-1:NUM_SRC] = '0;

  irq_pend_bank u_bank (
    .clk          (clk_fab),
    .rst_n        (rst_fab_n),
    .set_i        (set_vec),
    .mask_we_i    (mask_we_i),
    .mask_grp_i   (mask_grp_i),
    .mask_wdata_i (mask_wdata_i),
    .clr_we_i     (clr_we_i),
    .clr_grp_i    (clr_grp_i),
    .clr_wdata_i  (clr_wdata_i),
    .rd_grp_i     (rd_grp_i),
    .pend_rd_o    (pend_rd_o),
    .summary_o    (irq_summary_o)
  );

  // R9
  xdom_quiet_in_reset_chk: assert property (@(posedge clk_fab) disable iff (!rst_fab_n)
    !rst_xdom_n |-> (set_vec[XDOM_N-1:0] == '0));
endmodule

// File: tb/test_irq_leaf_collector.sv
`timescale 1ns/1ps
module test_irq_leaf_collector;
  logic clk_fab = 1'b0, clk_src = 1'b0;
  logic rst_fab_n = 1'b0, rst_src_n = 1'b0;
  logic [5:0]  src_lvl = '0;
  logic [24:0] src_evt = '0;
  logic [66:0] fab_evt = '0;
  logic        mask_we = 1'b0, clr_we = 1'b0;
  logic [1:0]  mask_grp = '0, clr_grp = '0, rd_grp = '0;
  logic [31:0] mask_wdata = '0, clr_wdata = '0;
  logic [31:0] pend_rd;
  logic        summary;

  always #10  clk_fab = ~clk_fab;
  always #3.5 clk_src = ~clk_src;

  irq_leaf_collector i_irq_leaf_collector (
    .clk_fab(clk_fab), .rst_fab_n(rst_fab_n), .clk_src(clk_src), .rst_src_n(rst_src_n),
    .src_lvl_i(src_lvl), .src_evt_i(src_evt), .fab_evt_i(fab_evt),
    .mask_we_i(mask_we), .mask_grp_i(mask_grp), .mask_wdata_i(mask_wdata),
    .clr_we_i(clr_we), .clr_grp_i(clr_grp), .clr_wdata_i(clr_wdata),
    .rd_grp_i(rd_grp), .pend_rd_o(pend_rd), .irq_summary_o(summary));

  // ---------------- reference model ----------------
  logic [127:0] m_pend, m_mask, m_setv, m_clrv, m_land_req = '0, m_land_prev;
  logic [5:0]   m_lvl = '0;
  logic         m_sum;
  bit           busy = 1'b0, running = 1'b0;
  int           checks = 0, errors = 0, cyc_checks = 0, cyc_errors = 0;

  always @(posedge clk_fab or negedge rst_fab_n) begin
    if (!rst_fab_n) begin
      m_pend = '0; m_mask = '1; m_sum = 1'b0; m_land_prev = m_land_req;
    end else begin
      m_sum = 1'b0;
      for (int i = 0; i < 98; i++) if (m_pend[i] && !m_mask[i]) m_sum = 1'b1;
      m_setv = '0;
      for (int k = 0; k < 67; k++) m_setv[31+k] = fab_evt[k];
      for (int k = 0; k < 6; k++)  if (m_lvl[k]) m_setv[k] = 1'b1;
      m_setv = m_setv | (m_land_req ^ m_land_prev);
      m_land_prev = m_land_req;
      m_clrv = '0;
      if (clr_we) for (int k = 0; k < 32; k++) if (clr_wdata[k]) m_clrv[clr_grp*32+k] = 1'b1;
      m_pend = (m_pend & ~m_clrv) | m_setv;
      if (mask_we) for (int k = 0; k < 32; k++) m_mask[mask_grp*32+k] = mask_wdata[k];
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk_fab) begin
    #5;
    if (running) begin
      logic [31:0] exp_w, ign;
      exp_w = m_pend[rd_grp*32 +: 32];
      ign = (busy && rd_grp == 2'd0) ? 32'h7FFF_FFFF : 32'h0;
      cyc_checks++;
      if ((pend_rd & ~ign) !== (exp_w & ~ign)) begin
        cyc_errors++;
        $display("FAIL R10 cycle image grp=%0d act=%h exp=%h", rd_grp, pend_rd, exp_w);
      end
      if (!busy) begin
        cyc_checks++;
        if (summary !== m_sum) begin
          cyc_errors++;
          $display("FAIL R7 cycle summary act=%b exp=%b", summary, m_sum);
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_fab);
  endtask

  task automatic peek_grp(input int g, output logic [31:0] v);
    rd_grp = 2'(g);
    #2;
    v = pend_rd;
  endtask

  task automatic fab_pulse(input int b);
    @(negedge clk_fab); fab_evt[b-31] = 1'b1;
    @(negedge clk_fab); fab_evt = '0;
  endtask

  task automatic clr(input int g, input logic [31:0] d);
    @(negedge clk_fab); clr_we = 1'b1; clr_grp = 2'(g); clr_wdata = d;
    @(negedge clk_fab); clr_we = 1'b0; clr_wdata = '0;
  endtask

  task automatic set_mask(input int g, input logic [31:0] d);
    @(negedge clk_fab); mask_we = 1'b1; mask_grp = 2'(g); mask_wdata = d;
    @(negedge clk_fab); mask_we = 1'b0;
  endtask

  task automatic src_pulse(input int b);
    logic [31:0] v;
    busy = 1'b1;
    @(negedge clk_src); src_evt[b-6] = 1'b1;
    @(negedge clk_src); src_evt = '0;
    cyc(5);
    peek_grp(0, v);
    chk("R3 event within 5 fabric cycles", 32'(v[b]), 32'd1);
    cyc(3);
    m_land_req[b] = ~m_land_req[b];
    cyc(2);
    busy = 1'b0;
  endtask

  task automatic set_lvl(input int b, input logic v);
    busy = 1'b1;
    @(negedge clk_src); src_lvl[b] = v;
    cyc(8);
    m_lvl[b] = v;
    cyc(2);
    busy = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 20);
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks + cyc_checks + 1, errors + cyc_errors + 1);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    cyc(4);
    rst_fab_n = 1'b1; rst_src_n = 1'b1;
    cyc(4);
    running = 1'b1;

    // R1 reset state
    chk("R1 summary after reset", 32'(summary), 32'd0);
    for (int g = 0; g < 4; g++) begin
      peek_grp(g, v);
      chk("R1 pending after reset", v, 32'd0);
    end
    // R1 masks all set: latched bit does not reach summary; R2 latch
    fab_pulse(31);
    cyc(2);
    peek_grp(0, v);
    chk("R2 fabric bit 31 latched", v, 32'h8000_0000);
    chk("R1 reset mask blocks summary", 32'(summary), 32'd0);

    // R6 unmask everything
    for (int g = 0; g < 4; g++) set_mask(g, 32'h0);
    cyc(2);
    chk("R6 unmasked summary", 32'(summary), 32'd1);
    clr(0, 32'h8000_0000);
    cyc(2);
    peek_grp(0, v);
    chk("R5 clear bit 31", v, 32'd0);
    chk("R7 summary drops", 32'(summary), 32'd0);

    // R2 two fabric sources in one cycle
    @(negedge clk_fab); fab_evt[33] = 1'b1; fab_evt[66] = 1'b1;
    @(negedge clk_fab); fab_evt = '0;
    peek_grp(2, v); chk("R2 bit 64 group2", v, 32'h1);
    peek_grp(3, v); chk("R2 bit 97 group3", v, 32'h2);
    // R5 zeros do nothing
    clr(2, 32'hFFFF_FFFE);
    peek_grp(2, v); chk("R5 zero bits ignored", v, 32'h1);
    clr(3, 32'h2);
    peek_grp(3, v); chk("R5 clear bit 97", v, 32'h0);
    // R5 set wins over clear
    @(negedge clk_fab); fab_evt[9] = 1'b1; clr_we = 1'b1; clr_grp = 2'd1; clr_wdata = 32'h100;
    @(negedge clk_fab); fab_evt = '0; clr_we = 1'b0; clr_wdata = '0;
    peek_grp(1, v); chk("R5 set wins same cycle", v, 32'h100);
    clr(2, 32'hFFFF_FFFF);
    // R6 mask bit 40
    set_mask(1, 32'h100);
    cyc(3);
    chk("R6 masked bit keeps summary low", 32'(summary), 32'd0);
    peek_grp(1, v); chk("R6 masked bit still pending", v, 32'h100);
    set_mask(1, 32'h0);
    cyc(2);
    chk("R6 unmask raises summary", 32'(summary), 32'd1);
    clr(1, 32'h100);
    cyc(2);

    // R7 exact one-cycle lag
    @(negedge clk_fab); fab_evt[19] = 1'b1;
    @(negedge clk_fab); fab_evt = '0;
    peek_grp(1, v);
    chk("R7 pending visible first", v, 32'h4_0000);
    chk("R7 summary not yet", 32'(summary), 32'd0);
    @(negedge clk_fab);
    chk("R7 summary one cycle later", 32'(summary), 32'd1);
    clr(1, 32'h4_0000);
    chk("R7 summary lags the clear", 32'(summary), 32'd1);
    @(negedge clk_fab);
    chk("R7 summary falls after lag", 32'(summary), 32'd0);

    // R3 narrow crossing events
    src_pulse(6);
    src_pulse(30);
    peek_grp(0, v); chk("R3 bits 6 and 30", v, 32'h4000_0040);
    clr(0, 32'hFFFF_FFFF);
    src_pulse(12);
    clr(0, 32'h1000);
    peek_grp(0, v); chk("R3 cleared between events", v, 32'h0);
    src_pulse(12);
    peek_grp(0, v); chk("R3 second event arrives", v, 32'h1000);
    busy = 1'b1;
    @(negedge clk_src); src_evt[15-6] = 1'b1;
    @(negedge clk_src); src_evt = '0; src_evt[22-6] = 1'b1;
    @(negedge clk_src); src_evt = '0;
    cyc(8);
    m_land_req[15] = ~m_land_req[15];
    m_land_req[22] = ~m_land_req[22];
    cyc(2);
    busy = 1'b0;
    peek_grp(0, v); chk("R3 back-to-back sources", v, 32'h0040_9000);
    clr(0, 32'hFFFF_FFFF);
    cyc(2);

    // R4 level flags
    set_lvl(0, 1'b1);
    peek_grp(0, v); chk("R4 level sets", v, 32'h1);
    set_lvl(0, 1'b0);
    peek_grp(0, v); chk("R4 latched after level falls", v, 32'h1);
    clr(0, 32'h1);
    peek_grp(0, v); chk("R4 cleared after fall", v, 32'h0);
    set_lvl(5, 1'b1);
    clr(0, 32'h20);
    peek_grp(0, v); chk("R4 clear while high re-sets", v, 32'h20);
    set_lvl(5, 1'b0);
    clr(0, 32'h20);
    peek_grp(0, v); chk("R4 final clear", v, 32'h0);

    // R9 compute-domain reset
    set_lvl(2, 1'b1);
    busy = 1'b1;
    @(negedge clk_fab); rst_src_n = 1'b0; m_lvl[2] = 1'b0;
    clr(0, 32'h4);
    cyc(2);
    busy = 1'b0;
    peek_grp(0, v); chk("R9 level blocked in reset", v, 32'h0);
    @(negedge clk_src); src_evt[20-6] = 1'b1;
    @(negedge clk_src); src_evt = '0;
    cyc(8);
    peek_grp(0, v); chk("R9 event blocked in reset", v, 32'h0);
    busy = 1'b1;
    @(negedge clk_fab); rst_src_n = 1'b1;
    cyc(10);
    m_lvl[2] = 1'b1;
    cyc(2);
    busy = 1'b0;
    peek_grp(0, v); chk("R9 level resumes, no spurious event", v, 32'h4);
    set_lvl(2, 1'b0);
    clr(0, 32'h4);

    // R8 unused bits
    @(negedge clk_fab); fab_evt = '1;
    @(negedge clk_fab); fab_evt = '0;
    peek_grp(3, v); chk("R8 bits 98..127 zero", v, 32'h3);
    peek_grp(1, v); chk("R2 full group1", v, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) clr(g, 32'hFFFF_FFFF);
    cyc(3);
    chk("R7 summary idle at end", 32'(summary), 32'd0);

    running = 1'b0;
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks + cyc_checks, errors + cyc_errors);
    $finish;
  end
endmodule